// File: doc/BRIEF.md
# USB Host Bus Control Register

This block is the host-side control word that software uses to drive bus-level actions on a USB port. It stores a two-bit speed policy and three action bits. One bit asks for a bus reset, one asks for a resume, and one turns start-of-frame generation on. The register is reached through a plain single-cycle write strobe and a combinational read path. Only one address decodes to it.

Toward the line-state driver, the block presents level requests for reset and resume. Each request stays high until the driver returns a one-cycle done pulse. Hardware also changes the bits on its own. Starting a reset forces frame generation on and cancels a pending resume. An upstream resume event turns frame generation on. A device disconnect drops both pending actions. Software may also abort a running reset by writing zero to its bit.

Top module: `usb_host_busctl`

## Requirements
- R1: After reset deassertion every stored bit is 0: `sof_en`, `reset_req` and `resume_req` are low, `speed_mode` is 0, and a read of the register returns 0.
- R2: A write to the register address stores `wr_data[13:12]` as `speed_mode`, which reads back at bits 13:12. The codes are: 0 = start full speed and move to high speed by the high-speed reset if the device allows it; 1 = low power, never high speed; 2 = forced high speed; 3 = forced full speed.
- R3: Register bits other than 13:12 and 10:8 always read 0. A read at any other address returns 0. A write at any other address changes nothing.
- R4: Writing 1 to bit 9 raises `reset_req` on the next cycle. The request stays high, and bit 9 reads 1, until the cycle after a `reset_done` pulse.
- R5: Writing 0 to bit 9 while `reset_req` is high drops it on the next cycle (abort).
- R6: A write with bit 9 = 1 sets bit 8 (`sof_en`) and clears bit 10 (`resume_req`) on the next cycle, whatever the written values of bits 8 and 10.
- R7: Writing 1 to bit 10 while bit 8 is 1 raises `resume_req`, which holds until the cycle after a `resume_done` pulse. Writing 0 to bit 10 has no effect.
- R8: A write of 1 to bit 10 while bit 8 reads 0 is ignored, so `resume_req` stays low.
- R9: A `up_resume_evt` pulse sets bit 8 on the next cycle, even if the same cycle writes 0 to it.
- R10: A `disconnect_evt` pulse clears both `reset_req` and `resume_req` on the next cycle.
- R11: When a hardware event and a software write hit the same bit in the same cycle, the hardware event wins. A done pulse or a disconnect beats a write of 1, and a set event beats a write of 0.
- R12: With no set event, a write stores bit 8 from `wr_data[8]`, so `sof_en` follows the written value. When `sof_en` is low the bus is left idle; when it is high frames, or low-speed keep-alives, are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` (combinational) |
| reset_done | input | 1 | Pulse: bus reset signalling finished |
| resume_done | input | 1 | Pulse: resume signalling finished |
| up_resume_evt | input | 1 | Pulse: upstream resume detected |
| disconnect_evt | input | 1 | Pulse: device disconnect detected |
| reset_req | output | 1 | Level request to send a bus reset |
| resume_req | output | 1 | Level request to send a resume |
| sof_en | output | 1 | Frame generation enable |
| speed_mode | output | 2 | Speed policy code |

## Verification
The critical overlap is a software write landing in the same cycle as a hardware event on the same bit. Examples are a write of 1 to bit 9 together with `reset_done` or `disconnect_evt`, and a write of 0 to bit 8 together with `up_resume_evt`. The bench provokes these overlaps with directed cycles. It also provokes them with random cycles in which writes and event pulses are drawn independently. Each cycle is judged against a bench model of the next-state rules, in which hardware always overrides the write.

// File: rtl/usb_host_busctl.sv
module usb_host_busctl #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              reset_done,
  input  logic              resume_done,
  input  logic              up_resume_evt,
  input  logic              disconnect_evt,
  output logic              reset_req,
  output logic              resume_req,
  output logic              sof_en,
  output logic [1:0]        speed_mode
);
  localparam int SOF_BIT = 8;
  localparam int RST_BIT = 9;
  localparam int RSM_BIT = 10;
  localparam int SPD_LO  = 12;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic hit, wr, rst_start;
  logic sof_q, rst_q, rsm_q;
  logic [1:0] spd_q;

  assign hit       = (addr == HIT_ADDR);
  assign wr        = wr_en && hit;
  assign rst_start = wr && wr_data[RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)   spd_q <= '0;
    else if (wr)  spd_q <= wr_data[SPD_LO +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          sof_q <= 1'b0;
    else if (up_resume_evt || rst_start) sof_q <= 1'b1;
    else if (wr)                         sof_q <= wr_data[SOF_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             rst_q <= 1'b0;
    else if (reset_done || disconnect_evt)  rst_q <= 1'b0;
    else if (wr)                            rst_q <= wr_data[RST_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                            rsm_q <= 1'b0;
    else if (resume_done || disconnect_evt || rst_start)   rsm_q <= 1'b0;
    else if (wr && wr_data[RSM_BIT] && sof_q)              rsm_q <= 1'b1;
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      rd_data[SPD_LO +: 2] = spd_q;
      rd_data[RSM_BIT]     = rsm_q;
      rd_data[RST_BIT]     = rst_q;
      rd_data[SOF_BIT]     = sof_q;
    end
  end

  assign reset_req  = rst_q;
  assign resume_req = rsm_q;
  assign sof_en     = sof_q;
  assign speed_mode = spd_q;
endmodule

// File: rtl/usb_host_busctl_chk.sv
module usb_host_busctl_chk #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              reset_done,
  input logic              resume_done,
  input logic              up_resume_evt,
  input logic              disconnect_evt,
  input logic              reset_req,
  input logic              resume_req,
  input logic              sof_en,
  input logic [1:0]        speed_mode
);
  localparam logic [DATA_W-1:0] LIVE = DATA_W'(32'h3700);
  logic hitw;
  assign hitw = wr_en && (addr == ADDR_W'(REG_OFFSET));

  // R3
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == '0);
  // R4
  reset_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> !reset_req);
  // R6
  reset_forces_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hitw && wr_data[9]) |=> (sof_en && !resume_req));
  // R7
  resume_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |=> !resume_req);
  // R8
  resume_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_en && !resume_req) |=> !resume_req);
  // R9
  upstream_sets_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_resume_evt |=> sof_en);
  // R10
  disconnect_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect_evt |=> (!reset_req && !resume_req));
endmodule

bind usb_host_busctl usb_host_busctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .reset_done(reset_done), .resume_done(resume_done),
  .up_resume_evt(up_resume_evt), .disconnect_evt(disconnect_evt),
  .reset_req(reset_req), .resume_req(resume_req), .sof_en(sof_en),
  .speed_mode(speed_mode)
);

// File: tb/usb_host_busctl_test.sv
`timescale 1ns/1ps
module usb_host_busctl_test;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] OFF = 12'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic reset_done = 1'b0, resume_done = 1'b0, up_resume_evt = 1'b0, disconnect_evt = 1'b0;
  logic reset_req, resume_req, sof_en;
  logic [1:0] speed_mode;

  int vectors = 0, errors = 0;
  bit finished = 0;
  logic m_sof = 0, m_rst = 0, m_rsm = 0;
  logic [1:0] m_spd = 0;

  always #2.5 clk = ~clk;

  usb_host_busctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .reset_done(reset_done), .resume_done(resume_done),
    .up_resume_evt(up_resume_evt), .disconnect_evt(disconnect_evt),
    .reset_req(reset_req), .resume_req(resume_req), .sof_en(sof_en),
    .speed_mode(speed_mode)
  );

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == OFF) begin
      r[13:12] = m_spd; r[10] = m_rsm; r[9] = m_rst; r[8] = m_sof;
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "reset_req", DW'(reset_req), DW'(m_rst));
    check(tag, "resume_req", DW'(resume_req), DW'(m_rsm));
    check(tag, "sof_en", DW'(sof_en), DW'(m_sof));
    check(tag, "speed_mode", DW'(speed_mode), DW'(m_spd));
  endtask

  // drive one cycle just after a negedge, check read path, update model, check after edge
  task automatic cyc(string tag, logic w, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic rd_ev, logic rs_ev, logic up_ev, logic dc_ev);
    logic hw, start;
    wr_en = w; addr = a; wr_data = d;
    reset_done = rd_ev; resume_done = rs_ev; up_resume_evt = up_ev; disconnect_evt = dc_ev;
    #1;
    check(tag, "rd_data", rd_data, model_read(a));
    hw = w && (a == OFF);
    start = hw && d[9];
    begin
      logic n_sof, n_rst, n_rsm;
      n_sof = (up_ev || start) ? 1'b1 : (hw ? d[8] : m_sof);
      n_rst = (rd_ev || dc_ev) ? 1'b0 : (hw ? d[9] : m_rst);
      n_rsm = (rs_ev || dc_ev || start) ? 1'b0 : ((hw && d[10] && m_sof) ? 1'b1 : m_rsm);
      if (hw) m_spd = d[13:12];
      m_sof = n_sof; m_rst = n_rst; m_rsm = n_rsm;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr(string tag, logic [DW-1:0] d);
    cyc(tag, 1'b1, OFF, d, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, OFF, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all("R1");
    #1 check("R1", "rd_data", rd_data, '0);

    // R2: each speed code, with all-ones junk elsewhere for R3
    for (int s = 0; s < 4; s++) wr("R2", 32'hFFFF_C0FF | (DW'(s) << 12));
    wr("R3", 32'hFFFF_FFFF & ~32'h0000_0600);
    cyc("R3", 1'b1, 12'h404, 32'h0000_3700, 0, 0, 0, 0);
    cyc("R3", 1'b0, 12'h000, '0, 0, 0, 0, 0);

    // R4: reset request held until done
    wr("R4", 32'h0000_0200);
    repeat (3) idle("R4");
    cyc("R4", 1'b0, OFF, '0, 1, 0, 0, 0);
    idle("R4");

    // R5: abort
    wr("R5", 32'h0000_0200);
    idle("R5");
    wr("R5", 32'h0000_0100);

    // R12: SOF bit follows writes
    wr("R12", 32'h0000_0000);
    wr("R12", 32'h0000_0100);

    // R7: resume with SOF on, write 0 no effect
    wr("R7", 32'h0000_0500);
    wr("R7", 32'h0000_0100);
    idle("R7");
    cyc("R7", 1'b0, OFF, '0, 0, 1, 0, 0);

    // R6: reset request clears resume, forces SOF
    wr("R6", 32'h0000_0500);
    wr("R6", 32'h0000_0200);
    cyc("R6", 1'b0, OFF, '0, 1, 0, 0, 0);

    // R8: resume blocked when SOF off
    wr("R8", 32'h0000_0000);
    wr("R8", 32'h0000_0400);
    idle("R8");

    // R9: upstream resume beats a write of 0
    cyc("R9", 1'b1, OFF, 32'h0, 0, 0, 1, 0);
    wr("R9", 32'h0000_0000);
    cyc("R9", 1'b0, OFF, '0, 0, 0, 1, 0);

    // R10: disconnect clears both
    wr("R10", 32'h0000_0500);
    wr("R10", 32'h0000_0700);
    wr("R10", 32'h0000_0500);
    cyc("R10", 1'b0, OFF, '0, 0, 0, 0, 1);

    // R11: collisions
    cyc("R11", 1'b1, OFF, 32'h0000_0200, 1, 0, 0, 0);
    cyc("R11", 1'b1, OFF, 32'h0000_0200, 0, 0, 0, 1);
    wr("R11", 32'h0000_0100);
    cyc("R11", 1'b1, OFF, 32'h0000_0500, 0, 1, 0, 0);

    // random mix, R11 collisions among them
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      w = ($urandom % 3) != 0;
      a = (($urandom % 8) == 0) ? AW'($urandom) : OFF;
      d = $urandom;
      if (($urandom % 4) != 0) d[9] = 1'b0;
      cyc("R11", w, a, d, ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 10) == 0, ($urandom % 12) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule